// File: doc/BRIEF.md
# Compare-Match Interval Timer Group

This block holds a small group of interval timer channels behind one simple register bus. Each channel has an up-counter, a compare register and a control/status register. A start register shared by all channels holds one run bit per channel. While its run bit is set, a channel's prescaler produces count ticks at a programmable fraction of the clock.

On the tick after the counter has reached the compare value, the counter returns to zero and a sticky match flag is set. Software can therefore treat each flag event as exactly one full compare period. The interrupt line of a channel follows the flag while the channel's enable bit is set. Software clears the flag with a read-modify-write of control/status, writing the flag bit as zero.

The counter width is a parameter, either 16 or 32. The width sets the register spacing inside a channel window and the layout of the control/status bits. It also selects which prescale codes exist, and whether the channel has a second flag for a counter rollover.

Top module: `cmt_group`

## Requirements
- R1: After reset, control/status reads 0, the counter reads 0, the compare register reads all ones, the start register reads 0 and every irq bit is 0.
- R2: The start register is at byte address 0x00. Channel k occupies a window at 0x10 + 0x10*k, with control/status at +0, the counter at +STEP and compare at +2*STEP. STEP is 2 for the 16-bit variant and 4 for the 32-bit variant. Any other address reads 0.
- R3: Start bit k (1 = run) gates channel k. While the bit is 0, the counter holds and the prescaler is cleared. The first increment lands exactly one prescale period (DIV cycles) after the clock edge that writes the bit to 1.
- R4: Prescale in the 16-bit variant: control bits [1:0] = c gives DIV = 8*4^c. Prescale in the 32-bit variant: control bits [2:0] with bit 2 set gives DIV = 8*4^c[1:0], and with bit 2 clear gives DIV = 1.
- R5: On a tick with the counter equal to compare, the counter goes to 0 instead of incrementing, and the match flag is set. The flag is bit 7 in the 16-bit variant and bit 15 in the 32-bit variant. Starting from 0, the flag rises (compare+1)*DIV cycles after start.
- R6: The match flag is sticky. A control/status write with the flag bit at 0 clears it. A write with the flag bit at 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R7: irq[k] is 1 exactly while the match flag and the interrupt enable are both 1. The enable is control bit 6 in the 16-bit variant and bit 5 in the 32-bit variant.
- R8: A counter write takes effect on the write edge and overrides that cycle's tick. A compare write is used by the next tick.
- R9: In the 32-bit variant, a tick that moves the counter from all ones to 0 without a match sets a rollover flag at control bit 14. The rollover flag clears like the match flag and does not drive irq.
- R10: Channels are independent: running, matching and interrupting on one channel leave another channel's counter and irq unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, low bits used |
| bus_rdata | output | 32 | Read data, combinational from address while bus_en and not bus_we |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
The bench builds two copies of the block side by side, one with a 16-bit counter and one with a 32-bit counter, each with two channels. The 32-bit copy can run with no prescale, so the bench sweeps its compare values 0 to 15 one per cycle and pins the match and clear race to an exact edge. The 16-bit copy covers every prescale code and its register spacing. In both copies the expected flag time is computed as (compare+1)*DIV.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int unsigned PRE_W = 9;   // longest prescale is 512

  // log2 of the prescale divisor for a control clock-select code
  function automatic logic [3:0] div_log2(input logic wide, input logic [2:0] cks);
    logic [3:0] lg;
    lg = 4'd3 + {1'b0, cks[1:0], 1'b0};
    if (wide && !cks[2]) lg = 4'd0;
    return lg;
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int unsigned PRE_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] lg,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    mask = PRE_W'((32'd1 << lg) - 32'd1);
    tick = run && ((pre_q & mask) == mask);
    pre_d = run ? pre_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3: a stopped channel restarts its prescale period from zero
  p_idle_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ctrl_we,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [15:0]      ctrl_rd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq
);

  localparam bit          WIDE     = (CNT_W == 32);
  localparam int unsigned FLAG_BIT = WIDE ? 15 : 7;
  localparam int unsigned IE_BIT   = WIDE ? 5 : 6;
  localparam int unsigned ROLL_BIT = 14;

  logic [CNT_W-1:0] cnt_d, cmp_d;
  logic             flag_q, flag_d, roll_q, roll_d, ie_q, ie_d;
  logic [2:0]       cks_q, cks_d;
  logic             tick, eq, match_ev, wrap_ev;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;

  cmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .lg   (div_log2(WIDE, cks_q)),
    .tick (tick)
  );

  always_comb begin
    eq       = (cnt_q == cmp_q);
    match_ev = tick && !cnt_we && eq;
    wrap_ev  = tick && !cnt_we && !eq && (cnt_q == '1);

    cnt_d = cnt_q;
    if (cnt_we)        cnt_d = wdata;
    else if (match_ev) cnt_d = '0;
    else if (tick)     cnt_d = cnt_q + 1'b1;

    cmp_d = cmp_we ? wdata : cmp_q;

    flag_d = ctrl_we ? (flag_q & wdata[FLAG_BIT]) : flag_q;
    if (match_ev) flag_d = 1'b1;

    roll_d = 1'b0;
    if (WIDE) roll_d = wrap_ev | (ctrl_we ? (roll_q & wdata[ROLL_BIT]) : roll_q);

    ie_d  = ctrl_we ? wdata[IE_BIT] : ie_q;
    cks_d = cks_q;
    if (ctrl_we) cks_d = WIDE ? wdata[2:0] : {1'b0, wdata[1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '1;
      flag_q <= 1'b0;
      roll_q <= 1'b0;
      ie_q   <= 1'b0;
      cks_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
      roll_q <= roll_d;
      ie_q   <= ie_d;
      cks_q  <= cks_d;
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[FLAG_BIT] = flag_q;
    ctrl_rd[IE_BIT]   = ie_q;
    ctrl_rd[1:0]      = cks_q[1:0];
    if (WIDE) begin
      ctrl_rd[2]        = cks_q[2];
      ctrl_rd[ROLL_BIT] = roll_q;
    end
  end

  assign irq = flag_q & ie_q;

  // R3: no run, no write -> counter frozen
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt_q));

  // R5: a match returns the counter to zero and raises the flag
  p_clear_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && (cnt_q == cmp_q)) |=> ((cnt_q == '0) && flag_q));

  // R5: any other tick advances by exactly one
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && (cnt_q != cmp_q)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R6: the flag only falls through a control write
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ctrl_we) |=> flag_q);

  // R8: a counter write lands on its edge
  p_cnt_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/cmt_group.sv
module cmt_group #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CH_BASE   = 16,
  parameter int unsigned CH_STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int unsigned STEP = (CNT_W == 32) ? 4 : 2;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [NUM_CH-1:0] start_q, start_d;
  logic              start_hit, start_we;
  logic [31:0]       ch_rd [NUM_CH];
  logic              unused_top;

  assign unused_top = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    start_hit = bus_en && (bus_addr == '0);
    start_we  = start_hit && bus_we;
    start_d   = start_we ? bus_wdata[NUM_CH-1:0] : start_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) start_q <= '0;
    else             start_q <= start_d;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE + k*CH_STRIDE);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CH_BASE + k*CH_STRIDE + STEP);
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(CH_BASE + k*CH_STRIDE + 2*STEP);

    logic             hit_ctrl, hit_cnt, hit_cmp;
    logic [15:0]      ctrl_rd;
    logic [CNT_W-1:0] cnt_v, cmp_v;

    assign hit_ctrl = bus_en && (bus_addr == A_CTRL);
    assign hit_cnt  = bus_en && (bus_addr == A_CNT);
    assign hit_cmp  = bus_en && (bus_addr == A_CMP);

    cmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .run    (start_q[k]),
      .ctrl_we(hit_ctrl && bus_we),
      .cnt_we (hit_cnt && bus_we),
      .cmp_we (hit_cmp && bus_we),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .ctrl_rd(ctrl_rd),
      .cnt_q  (cnt_v),
      .cmp_q  (cmp_v),
      .irq    (irq[k])
    );

    assign ch_rd[k] = bus_we   ? 32'd0 :
                      hit_ctrl ? 32'(ctrl_rd) :
                      hit_cnt  ? 32'(cnt_v) :
                      hit_cmp  ? 32'(cmp_v) : 32'd0;
  end

  always_comb begin
    bus_rdata = (start_hit && !bus_we) ? 32'(start_q) : 32'd0;
    for (int k = 0; k < NUM_CH; k++) bus_rdata = bus_rdata | ch_rd[k];
  end

  // R3: run bits change only through a start-register write
  p_start_stable_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !start_we |=> $stable(start_q));

endmodule

// File: tb/cmt_group_tb_top.sv
module cmt_group_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en16 = 1'b0, en32 = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata16, rdata32;
  logic [1:0]  irq16, irq32;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  cmt_group #(.CNT_W(16), .NUM_CH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(en16), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata16), .irq(irq16));

  cmt_group #(.CNT_W(32), .NUM_CH(2)) dut32_i (
    .clk(clk), .rst_n(rst_n), .bus_en(en32), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata32), .irq(irq32));

  function automatic logic [7:0] a_of(input bit w32, input int ch, input int r);
    return 8'(16 + 16*ch + (w32 ? 4 : 2)*r);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit w32, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    en16 = !w32; en32 = w32; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en16 = 1'b0; en32 = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input bit w32, input logic [7:0] a, output logic [31:0] v);
    en16 = !w32; en32 = w32; we = 1'b0; addr = a;
    #1;
    v = w32 ? rdata32 : rdata16;
    en16 = 1'b0; en32 = 1'b0;
  endtask

  function automatic logic irq_of(input bit w32, input int ch);
    return w32 ? irq32[ch] : irq16[ch];
  endfunction

  task automatic wait_irq(input bit w32, input int ch, inout int n);
    while (!irq_of(w32, ch) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic prep(input bit w32, input int ch, input logic [31:0] ctrl, input logic [31:0] cmp);
    wr(w32, 8'h00, 32'd0);
    wr(w32, a_of(w32, ch, 1), 32'd0);
    wr(w32, a_of(w32, ch, 0), ctrl);
    wr(w32, a_of(w32, ch, 2), cmp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int w = 0; w < 2; w++) begin
      rd(w[0], a_of(w[0], 0, 0), v); chk("R1 ctrl", v, 0);
      rd(w[0], a_of(w[0], 0, 1), v); chk("R1 count", v, 0);
      rd(w[0], a_of(w[0], 1, 2), v); chk("R1 compare", v, w[0] ? 32'hffff_ffff : 32'h0000_ffff);
      rd(w[0], 8'h00, v);            chk("R1 start", v, 0);
    end
    chk("R1 irq", {28'd0, irq32, irq16}, 0);

    // R2 address map
    wr(0, 8'h24, 32'h1234); rd(0, 8'h24, v); chk("R2 cmp16 ch1", v, 32'h1234);
    wr(0, 8'h22, 32'h0055); rd(0, 8'h22, v); chk("R2 cnt16 ch1", v, 32'h55);
    wr(1, 8'h28, 32'hdead_beef); rd(1, 8'h28, v); chk("R2 cmp32 ch1", v, 32'hdead_beef);
    wr(1, 8'h24, 32'h0000_0077); rd(1, 8'h24, v); chk("R2 cnt32 ch1", v, 32'h77);
    rd(1, 8'h22, v); chk("R2 unmapped32", v, 0);
    rd(0, 8'h13, v); chk("R2 unmapped16", v, 0);

    // R3 first increment one full prescale period after start (DIV=32)
    prep(0, 0, 32'h41, 32'hffff);
    wr(0, 8'h00, 32'd1);
    repeat (31) @(negedge clk);
    rd(0, a_of(0, 0, 1), v); chk("R3 count before first tick", v, 0);
    @(negedge clk);
    rd(0, a_of(0, 0, 1), v); chk("R3 count after first tick", v, 1);

    // R4 R5 R7 16-bit sweep across prescale codes
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < ((c == 0) ? 10 : 2); m++) begin
        prep(0, 0, 32'h40 | c, m);
        wr(0, 8'h00, 32'd1);
        n = 0;
        wait_irq(0, 0, n);
        chk("R5 R4 flag time 16", n, (m + 1) * (8 << (2*c)));
        rd(0, a_of(0, 0, 0), v); chk("R5 flag bit7", v, 32'hc0 | c);
      end
    end

    // R4 R5 32-bit sweep, no prescale, then /8
    for (int m = 0; m < 16; m++) begin
      prep(1, 0, 32'h20, m);
      wr(1, 8'h00, 32'd1);
      n = 0;
      wait_irq(1, 0, n);
      chk("R5 R4 flag time 32", n, m + 1);
    end
    rd(1, a_of(1, 0, 0), v); chk("R5 flag bit15", v, 32'h8020);
    prep(1, 0, 32'h24, 2);
    wr(1, 8'h00, 32'd1);
    n = 0;
    wait_irq(1, 0, n);
    chk("R4 32-bit div8", n, 24);

    // R6 R7 flag handling (32-bit ch0 flag is set, ie=1)
    wr(1, a_of(1, 0, 0), 32'h8024);
    rd(1, a_of(1, 0, 0), v); chk("R6 write-one keeps flag", v, 32'h8024);
    wr(1, a_of(1, 0, 0), 32'h8000);
    chk("R7 irq off with enable 0", irq32[0], 0);
    rd(1, a_of(1, 0, 0), v); chk("R7 flag still set", v, 32'h8000);
    wr(1, a_of(1, 0, 0), 32'h0020);
    rd(1, a_of(1, 0, 0), v); chk("R6 clear", v, 32'h0020);
    chk("R7 irq low after clear", irq32[0], 0);

    // R6 match on the same edge as a clearing write
    prep(1, 0, 32'h20, 9);
    wr(1, 8'h00, 32'd1);
    repeat (8) @(negedge clk);
    wr(1, a_of(1, 0, 0), 32'h0020);
    rd(1, a_of(1, 0, 0), v); chk("R6 match beats clear", v, 32'h8020);
    chk("R7 irq with flag", irq32[0], 1);

    // R8 counter write immediate, compare write used by next tick
    prep(0, 0, 32'h40, 32'hffff);
    wr(0, 8'h00, 32'd1);
    wr(0, a_of(0, 0, 1), 32'h100);
    rd(0, a_of(0, 0, 1), v); chk("R8 counter write", v, 32'h100);
    prep(1, 0, 32'h20, 1000);
    wr(1, 8'h00, 32'd1);
    wr(1, a_of(1, 0, 2), 32'd20);
    n = 2;
    wait_irq(1, 0, n);
    chk("R8 new compare used", n, 21);

    // R9 rollover flag in the 32-bit variant
    prep(1, 0, 32'h20, 5);
    wr(1, a_of(1, 0, 1), 32'hffff_fffe);
    wr(1, 8'h00, 32'd1);
    repeat (2) @(negedge clk);
    rd(1, a_of(1, 0, 0), v); chk("R9 rollover set", v, 32'h4020);
    chk("R9 no irq from rollover", irq32[0], 0);
    wr(1, a_of(1, 0, 0), 32'h8020);
    rd(1, a_of(1, 0, 0), v); chk("R9 rollover cleared", v, 32'h0020);

    // R3 hold while stopped
    wr(1, 8'h00, 32'd0);
    rd(1, a_of(1, 0, 1), v);
    repeat (50) @(negedge clk);
    rd(1, a_of(1, 0, 1), v2); chk("R3 counter holds", v2, v);

    // R10 independent channels
    prep(0, 1, 32'h40, 3);
    wr(0, a_of(0, 0, 0), 32'h40);
    rd(0, a_of(0, 0, 1), v);
    wr(0, 8'h00, 32'd2);
    n = 0;
    wait_irq(0, 1, n);
    chk("R10 ch1 period", n, 32);
    chk("R10 ch0 irq quiet", irq16[0], 0);
    rd(0, a_of(0, 0, 1), v2); chk("R10 ch0 count unchanged", v2, v);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule